// File: doc/BRIEF.md
# Rule Port Group Checker

This block screens candidate rules against a packet's transport ports. Each cycle it takes up to eight rule identifiers, one per lane, together with the packet's source and destination port numbers. Every rule identifier selects a row in an internal table. The row holds up to four port groups. A group is unused, a single port, an inclusive port range, or a list. A list is either up to four ports compared in parallel or, for a group with hundreds of members, a shared membership bitmap indexed by port number. Each group names the port it tests, source or destination. A rule is kept when any of its used groups matches.

The results come out at a fixed latency of two cycles. One stage registers the table row and the bitmap bits, and the next registers the comparison results. Each lane returns its valid bit, its rule identifier and a keep bit. A packet-level flag is raised when any valid lane is kept, which tells downstream logic that the packet needs a full match. The group table and the bitmap are loaded through two simple write ports.

Top module: `rpg_port_check`

## Requirements
- R1: A lane presented with valid high returns its valid bit and rule identifier on the outputs exactly two clock cycles later. All eight lanes are handled every cycle.
- R2: A table write stores a 68-bit group word into the row given by the rule index, in the slot given by the group select (0 to 3). Bits [67:66] hold the kind: 0 unused, 1 single, 2 range, 3 list. Bit 65 set means the group tests the destination port, clear means the source port. Bit 64 set on a list selects the bitmap. Value k (k = 0..3) sits in bits [16k+15:16k].
- R3: A single group matches only when the tested port equals value 0.
- R4: A range group matches when value 0 <= port <= value 1, both bounds included.
- R5: A small list group (bit 64 clear) matches when the port equals any of values 0 to 3.
- R6: A bitmap list group (bit 64 set) matches when the bitmap bit at the port number is 1. Ports at or above 4096, the default bitmap size, never match.
- R7: A group tests only the port chosen by its direction bit. The other port has no effect on it.
- R8: A lane's keep bit is 1 when at least one used group of its rule matches. Unused groups never match, so a rule with no used groups is discarded.
- R9: The full-match flag is 1 in exactly the cycles where at least one lane's keep bit is 1.
- R10: A lane with valid low has keep low, whatever its rule identifier and the ports.
- R11: Reset clears the table, the bitmap and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Group table write enable |
| tbl_rule | input | RULE_W | Row (rule index) to write |
| tbl_sel | input | GSEL_W | Group slot within the row |
| tbl_data | input | 68 | Group word |
| map_we | input | 1 | Bitmap write enable |
| map_addr | input | BMP_W | Bitmap bit index |
| map_bit | input | 1 | Bitmap bit value |
| in_valid | input | LANES | Per-lane valid |
| in_rule | input | LANES*RULE_W | Per-lane rule identifier |
| in_sport | input | 16 | Packet source port |
| in_dport | input | 16 | Packet destination port |
| out_valid | output | LANES | Per-lane valid, delayed by two cycles |
| out_rule | output | LANES*RULE_W | Per-lane rule identifier, delayed by two cycles |
| out_keep | output | LANES | Per-lane keep bit |
| out_need_full | output | 1 | Packet needs a full match |

## Verification
Every lane result, and the full-match flag, is due two rising edges after the inputs are driven. The bench drives on a falling edge and samples on the falling edge two cycles later. It keeps the expected values in a two-deep history, which it shifts once per cycle. Expected keep bits come from a bench model of the table and bitmap. The model is evaluated before a write made in the same cycle is applied, and table loading happens only while all lanes are idle.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    localparam int PORT_W = 16;
    localparam int LIST_N = 4;

    typedef enum logic [1:0] {
        GK_NONE   = 2'd0,
        GK_SINGLE = 2'd1,
        GK_RANGE  = 2'd2,
        GK_LIST   = 2'd3
    } grp_kind_e;

    typedef struct packed {
        grp_kind_e                      kind;
        logic                           on_dst;
        logic                           use_map;
        logic [LIST_N-1:0][PORT_W-1:0]  val;
    } grp_t;

    localparam int GRP_BITS = $bits(grp_t);
endpackage

// File: rtl/rpg_table.sv
module rpg_table
    import rpg_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int RULE_W = 6,
    parameter int GROUPS = 4,
    parameter int BMP_W  = 12,
    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int DEPTH  = 1 << RULE_W,
    localparam int BMP_N  = 1 << BMP_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [RULE_W-1:0]               wr_rule,
    input  logic [GSEL_W-1:0]               wr_sel,
    input  grp_t                            wr_grp,
    input  logic                            map_we,
    input  logic [BMP_W-1:0]                map_addr,
    input  logic                            map_bit,
    input  logic [LANES-1:0][RULE_W-1:0]    rd_rule,
    input  logic [PORT_W-1:0]               rd_sport,
    input  logic [PORT_W-1:0]               rd_dport,
    output grp_t [LANES-1:0][GROUPS-1:0]    rd_grp,
    output logic                            rd_sbit,
    output logic                            rd_dbit
);
    grp_t [GROUPS-1:0] tbl_q [DEPTH];
    logic [BMP_N-1:0]  map_q;

    typedef struct packed {
        grp_t [LANES-1:0][GROUPS-1:0] grp;
        logic                         sbit;
        logic                         dbit;
    } rd_t;

    rd_t rd_d, rd_q;

    function automatic logic map_lookup(input logic [PORT_W-1:0] port,
                                        input logic [BMP_N-1:0] map);
        if ((port >> BMP_W) != '0) return 1'b0;
        return map[port[BMP_W-1:0]];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) tbl_q[r] <= '0;
            map_q <= '0;
        end else begin
            if (wr_en)  tbl_q[wr_rule][wr_sel] <= wr_grp;
            if (map_we) map_q[map_addr] <= map_bit;
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) rd_d.grp[l] = tbl_q[rd_rule[l]];
        rd_d.sbit = map_lookup(rd_sport, map_q);
        rd_d.dbit = map_lookup(rd_dport, map_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_grp  = rd_q.grp;
    assign rd_sbit = rd_q.sbit;
    assign rd_dbit = rd_q.dbit;
endmodule

// File: rtl/rpg_match.sv
module rpg_match
    import rpg_pkg::*;
#(
    parameter int GROUPS = 4
) (
    input  grp_t [GROUPS-1:0]   grps,
    input  logic [PORT_W-1:0]   sport,
    input  logic [PORT_W-1:0]   dport,
    input  logic                sbit,
    input  logic                dbit,
    output logic                hit
);
    logic [GROUPS-1:0] ghit;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [PORT_W-1:0] port;
        logic              mbit;
        logic [LIST_N-1:0] eq;
        logic              gh;

        assign port = grps[g].on_dst ? dport : sport;
        assign mbit = grps[g].on_dst ? dbit  : sbit;

        for (genvar k = 0; k < LIST_N; k++) begin : g_eq
            assign eq[k] = (grps[g].val[k] == port);
        end

        always_comb begin
            unique case (grps[g].kind)
                GK_SINGLE: gh = eq[0];
                GK_RANGE:  gh = (port >= grps[g].val[0]) && (port <= grps[g].val[1]);
                GK_LIST:   gh = grps[g].use_map ? mbit : (|eq);
                default:   gh = 1'b0;
            endcase
        end

        assign ghit[g] = gh;
    end

    assign hit = |ghit;
endmodule

// File: rtl/rpg_port_check.sv
module rpg_port_check
    import rpg_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int RULE_W = 6,
    parameter int GROUPS = 4,
    parameter int BMP_W  = 12,
    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tbl_we,
    input  logic [RULE_W-1:0]               tbl_rule,
    input  logic [GSEL_W-1:0]               tbl_sel,
    input  logic [GRP_BITS-1:0]             tbl_data,
    input  logic                            map_we,
    input  logic [BMP_W-1:0]                map_addr,
    input  logic                            map_bit,
    input  logic [LANES-1:0]                in_valid,
    input  logic [LANES-1:0][RULE_W-1:0]    in_rule,
    input  logic [PORT_W-1:0]               in_sport,
    input  logic [PORT_W-1:0]               in_dport,
    output logic [LANES-1:0]                out_valid,
    output logic [LANES-1:0][RULE_W-1:0]    out_rule,
    output logic [LANES-1:0]                out_keep,
    output logic                            out_need_full
);
    typedef struct packed {
        logic [LANES-1:0]               s1_vld;
        logic [LANES-1:0][RULE_W-1:0]   s1_rule;
        logic [PORT_W-1:0]              s1_sport;
        logic [PORT_W-1:0]              s1_dport;
        logic [LANES-1:0]               o_vld;
        logic [LANES-1:0][RULE_W-1:0]   o_rule;
        logic [LANES-1:0]               o_keep;
        logic                           o_need;
    } st_t;

    st_t st_d, st_q;

    grp_t [LANES-1:0][GROUPS-1:0] rd_grp;
    logic                         rd_sbit, rd_dbit;
    logic [LANES-1:0]             lane_hit;

    rpg_table #(
        .LANES(LANES), .RULE_W(RULE_W), .GROUPS(GROUPS), .BMP_W(BMP_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_rule  (tbl_rule),
        .wr_sel   (tbl_sel),
        .wr_grp   (grp_t'(tbl_data)),
        .map_we   (map_we),
        .map_addr (map_addr),
        .map_bit  (map_bit),
        .rd_rule  (in_rule),
        .rd_sport (in_sport),
        .rd_dport (in_dport),
        .rd_grp   (rd_grp),
        .rd_sbit  (rd_sbit),
        .rd_dbit  (rd_dbit)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rpg_match #(.GROUPS(GROUPS)) u_match (
            .grps  (rd_grp[l]),
            .sport (st_q.s1_sport),
            .dport (st_q.s1_dport),
            .sbit  (rd_sbit),
            .dbit  (rd_dbit),
            .hit   (lane_hit[l])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.s1_vld   = in_valid;
        st_d.s1_rule  = in_rule;
        st_d.s1_sport = in_sport;
        st_d.s1_dport = in_dport;
        st_d.o_vld    = st_q.s1_vld;
        st_d.o_rule   = st_q.s1_rule;
        st_d.o_keep   = st_q.s1_vld & lane_hit;
        st_d.o_need   = |(st_q.s1_vld & lane_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.o_vld;
    assign out_rule      = st_q.o_rule;
    assign out_keep      = st_q.o_keep;
    assign out_need_full = st_q.o_need;
endmodule

// File: rtl/rpg_port_check_chk.sv
module rpg_port_check_chk #(
    parameter int LANES  = 8,
    parameter int RULE_W = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [LANES-1:0]             in_valid,
    input logic [LANES-1:0][RULE_W-1:0] in_rule,
    input logic [LANES-1:0]             out_valid,
    input logic [LANES-1:0][RULE_W-1:0] out_rule,
    input logic [LANES-1:0]             out_keep,
    input logic                         out_need_full
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1

    AST_RULE_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_rule == $past(in_rule, 2))); // R1

    AST_KEEP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_keep & ~out_valid) == '0); // R10

    AST_NEED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_need_full == ($countones(out_keep) != 0)); // R9
endmodule

bind rpg_port_check rpg_port_check_chk #(.LANES(LANES), .RULE_W(RULE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_rule       (in_rule),
    .out_valid     (out_valid),
    .out_rule      (out_rule),
    .out_keep      (out_keep),
    .out_need_full (out_need_full)
);

// File: tb/rpg_port_check_tb.sv
module rpg_port_check_tb;
    localparam int CLK_P = 10;
    localparam int L = 8;
    localparam int RW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0;
    logic [RW-1:0] tbl_rule = '0;
    logic [1:0] tbl_sel = '0;
    logic [67:0] tbl_data = '0;
    logic map_we = 1'b0;
    logic [11:0] map_addr = '0;
    logic map_bit = 1'b0;
    logic [L-1:0] in_valid = '0;
    logic [L-1:0][RW-1:0] in_rule = '0;
    logic [15:0] in_sport = '0, in_dport = '0;
    logic [L-1:0] out_valid;
    logic [L-1:0][RW-1:0] out_rule;
    logic [L-1:0] out_keep;
    logic out_need_full;

    always #(CLK_P/2) clk = ~clk;

    rpg_port_check u_dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [67:0] mdl [64][4];
    bit mdl_map [4096];

    // staged write, applied on the next cycle() call
    bit w_tbl = 0, w_map = 0;
    int w_rule, w_sel, w_addr;
    logic [67:0] w_data;
    bit w_bit;

    // expected-value history: h0 = driven last cycle, h1 = two cycles ago
    bit h0_ok = 0, h1_ok = 0;
    logic [L-1:0] h0_v, h1_v, h0_k, h1_k;
    logic [L*RW-1:0] h0_r, h1_r, h0_m, h1_m;
    string h0_t, h1_t;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit group_hit(logic [67:0] e, logic [15:0] sp, logic [15:0] dp);
        logic [15:0] p;
        p = e[65] ? dp : sp;
        case (e[67:66])
            2'd1: return p == e[15:0];
            2'd2: return (p >= e[15:0]) && (p <= e[31:16]);
            2'd3: begin
                if (e[64]) return (p < 16'd4096) && mdl_map[p[11:0]];
                for (int k = 0; k < 4; k++) if (p == e[16*k +: 16]) return 1'b1;
                return 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit rule_hit(int r, logic [15:0] sp, logic [15:0] dp);
        for (int g = 0; g < 4; g++) if (group_hit(mdl[r][g], sp, dp)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic cycle(logic [L-1:0] v, logic [L-1:0][RW-1:0] rl,
                         logic [15:0] sp, logic [15:0] dp, string tag);
        logic [L-1:0] k;
        logic [L*RW-1:0] m;
        @(negedge clk);
        if (h1_ok && !finished) begin
            check({h1_t, " R1 valid"}, 64'(out_valid), 64'(h1_v));
            check({h1_t, " R1 rule"}, 64'(out_rule & h1_m), 64'(h1_r & h1_m));
            check({h1_t, " keep"}, 64'(out_keep), 64'(h1_k));
            check({h1_t, " R9 need"}, 64'(out_need_full), 64'(h1_k != '0));
        end
        h1_ok = h0_ok; h1_v = h0_v; h1_k = h0_k; h1_r = h0_r; h1_m = h0_m; h1_t = h0_t;
        k = '0; m = '0;
        for (int l = 0; l < L; l++) begin
            if (v[l]) begin
                k[l] = rule_hit(int'(rl[l]), sp, dp);
                m[l*RW +: RW] = '1;
            end
        end
        h0_ok = 1; h0_v = v; h0_k = k; h0_r = rl; h0_m = m; h0_t = tag;
        in_valid = v; in_rule = rl; in_sport = sp; in_dport = dp;
        tbl_we = w_tbl; map_we = w_map;
        if (w_tbl) begin
            tbl_rule = RW'(w_rule); tbl_sel = 2'(w_sel); tbl_data = w_data;
            mdl[w_rule][w_sel] = w_data;
        end
        if (w_map) begin
            map_addr = 12'(w_addr); map_bit = w_bit;
            mdl_map[w_addr] = w_bit;
        end
        w_tbl = 0; w_map = 0;
    endtask

    task automatic idle();
        cycle('0, '0, 16'd0, 16'd0, "idle");
    endtask

    // R2: group word layout kind[67:66], dst[65], map[64], value k at [16k+15:16k]
    task automatic set_grp(int r, int g, int kind, bit dst, bit big,
                           int v0, int v1, int v2, int v3);
        w_tbl = 1; w_rule = r; w_sel = g;
        w_data = {2'(kind), dst, big, 16'(v3), 16'(v2), 16'(v1), 16'(v0)};
        idle();
    endtask

    task automatic set_map(int a, bit b);
        w_map = 1; w_addr = a; w_bit = b;
        idle();
    endtask

    function automatic logic [L-1:0][RW-1:0] same(int r);
        logic [L-1:0][RW-1:0] x;
        for (int l = 0; l < L; l++) x[l] = RW'(r);
        return x;
    endfunction

    function automatic logic [15:0] pick();
        int s;
        s = int'($urandom_range(0, 9));
        case (s)
            0: return 16'd20;   1: return 16'd21;   2: return 16'd80;
            3: return 16'd443;  4: return 16'd1000; 5: return 16'd1001;
            6: return 16'd4100; 7: return 16'd65535;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [L-1:0][RW-1:0] mix;
        void'($urandom(32'd4242));
        for (int r = 0; r < 64; r++) for (int g = 0; g < 4; g++) mdl[r][g] = '0;
        for (int a = 0; a < 4096; a++) mdl_map[a] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset valid", 64'(out_valid), 0);
        check("R11 reset keep", 64'(out_keep), 0);
        check("R11 reset need", 64'(out_need_full), 0);

        // empty table after reset: every rule discarded
        cycle('1, same(1), 16'd80, 16'd80, "R11 R8 empty");
        idle(); idle();

        set_grp(1, 0, 1, 0, 0, 80, 0, 0, 0);
        cycle('1, same(1), 16'd80, 16'd5, "R3 single hit");
        cycle('1, same(1), 16'd81, 16'd80, "R3 R7 single miss");
        cycle('1, same(1), 16'd1, 16'd80, "R7 wrong side");

        set_grp(2, 1, 2, 1, 0, 100, 200, 0, 0);
        cycle('1, same(2), 16'd0, 16'd99, "R4 below");
        cycle('1, same(2), 16'd0, 16'd100, "R4 low bound");
        cycle('1, same(2), 16'd0, 16'd200, "R4 high bound");
        cycle('1, same(2), 16'd150, 16'd201, "R4 above");

        set_grp(3, 2, 3, 0, 0, 7, 9, 11, 13);
        cycle('1, same(3), 16'd11, 16'd0, "R5 list hit");
        cycle('1, same(3), 16'd13, 16'd0, "R5 list last");
        cycle('1, same(3), 16'd12, 16'd11, "R5 list miss");

        set_map(443, 1);
        set_map(5, 1);
        set_grp(4, 3, 3, 1, 1, 0, 0, 0, 0);
        cycle('1, same(4), 16'd0, 16'd443, "R6 map hit");
        cycle('1, same(4), 16'd443, 16'd444, "R6 map miss");
        cycle('1, same(4), 16'd0, 16'd4101, "R6 beyond map");
        cycle('1, same(4), 16'd0, 16'd0, "R6 small list value ignored");

        // rule 5: unused slot 0 plus single 22 on slot 3
        set_grp(5, 3, 1, 0, 0, 22, 0, 0, 0);
        cycle('1, same(5), 16'd22, 16'd0, "R8 any group");
        cycle('1, same(5), 16'd0, 16'd0, "R8 unused never matches");

        for (int l = 0; l < L; l++) mix[l] = RW'(l);
        cycle('1, mix, 16'd80, 16'd150, "R8 mixed lanes");
        cycle(8'b0101_0101, same(1), 16'd80, 16'd0, "R10 invalid lanes");
        cycle(8'b0000_0000, same(1), 16'd80, 16'd0, "R10 all idle");
        idle(); idle();

        for (int round = 0; round < 4; round++) begin
            for (int n = 0; n < 24; n++) begin
                logic [15:0] a, b;
                a = pick(); b = pick();
                if (a > b) begin logic [15:0] t; t = a; a = b; b = t; end
                set_grp(int'($urandom_range(8, 15)), int'($urandom_range(0, 3)),
                        int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                        int'(a), int'(b), int'(pick()), int'(pick()));
            end
            for (int n = 0; n < 6; n++) set_map(int'(pick()) % 4096, 1'($urandom));
            for (int n = 0; n < 300; n++) begin
                logic [L-1:0][RW-1:0] rl;
                for (int l = 0; l < L; l++) rl[l] = RW'($urandom_range(0, 15));
                cycle(L'($urandom), rl, pick(), pick(), "R2 R8 random");
            end
            idle(); idle();
        end
        idle(); idle();

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule